// File: doc/BRIEF.md
# Ping-Pong Dual FIFO Buffer

This block holds two synchronous FIFOs of identical width and depth behind one FIFO-style port. A single bank-select input gives each FIFO a role: one accepts writes and the other serves reads. A producer fills one bank while a consumer empties the bank that was filled earlier. Flipping the select swaps the roles, and the words already stored in either bank are kept.

The empty flag describes only the bank currently serving reads. Words written into the other bank do not clear it. Read data comes from a register that changes only when a word is actually popped. Because the two strobes always address different banks, a read and a write may happen in the same cycle.

Top module: `pp_dual_fifo`

## Requirements
- R1: With `bank_sel` = 0, writes enter bank A (index 0) while reads and `empty` use bank B (index 1). With `bank_sel` = 1 the roles swap. The select value present at a clock edge decides where that edge's write and read go.
- R2: `empty` is high exactly when the bank serving reads holds no words. Storing words in the bank taking writes leaves it high while the read-side bank is empty.
- R3: Each bank returns its words in the order they were written, including when they arrive in several bursts separated by select changes.
- R4: On a rising clock edge with `wr_en` high, the `wr_data` present at that edge is stored in the write-side bank. Data is WIDTH = 20 bits and each bank is DEPTH = 64 entries deep by default.
- R5: On a rising edge with `rd_en` high and the read-side bank non-empty, the oldest word of that bank is removed and appears on `rd_data` right after that edge. It holds there until the next successful read.
- R6: `rst` is asynchronous and active high. While it is high, both banks are empty and `empty` is high, with no clock edge needed.
- R7: A write into a write-side bank that already holds DEPTH words is dropped, and that bank's stored words are unchanged.
- R8: A read strobe while the read-side bank is empty removes nothing and leaves `rd_data` unchanged.
- R9: Changing `bank_sel` keeps the stored contents of both banks.
- R10: A read and a write in the same cycle both take effect, each on its own bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset |
| bank_sel | input | 1 | 0: write A / read B; 1: write B / read A |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | WIDTH | Registered word from the last successful read |
| empty | output | 1 | Read-side bank holds no words |

## Verification
A corrupted pointer or occupancy count in either bank shows up only when that bank turns to the read side. From then on the fault appears as a wrong or reordered `rd_data` on the first pop, or as `empty` asserting too early or too late at the end of a drain. For that reason every cycle is compared against two reference queues. The tests fill a bank past DEPTH and interleave select flips with bursts, so a counting error shows within the drain that follows. A misrouted strobe shows at once, because `empty` on the wrong bank is visible as soon as the select flips.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  localparam int unsigned DEF_WIDTH = 20;
  localparam int unsigned DEF_DEPTH = 64;
  localparam int unsigned NUM_BANKS = 2;

  // bank indices: select value names the write-side bank
  localparam logic BANK_A = 1'b0;
  localparam logic BANK_B = 1'b1;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/ppbuf_ram.sv
module ppbuf_ram #(
  parameter int unsigned WIDTH = 20,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = ppbuf_pkg::ptr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  // plain array with no reset so a block RAM can be inferred
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ppbuf_bank.sv
module ppbuf_bank #(
  parameter int unsigned WIDTH = 20,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = ppbuf_pkg::ptr_bits(DEPTH),
  localparam int unsigned CW = ppbuf_pkg::cnt_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] pop_data,
  output logic             popped,
  output logic             is_empty,
  output logic             is_full,
  output logic [CW-1:0]    level
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ;
  logic          do_push, do_pop;

  assign is_empty = (occ == '0);
  assign is_full  = (occ == FULL_LVL);
  assign do_push  = push_req && !is_full;
  assign do_pop   = pop_req && !is_empty;
  assign popped   = do_pop;
  assign level    = occ;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wptr <= '0;
    end else if (do_push) begin
      wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rptr <= '0;
    end else if (do_pop) begin
      rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      occ <= '0;
    end else begin
      unique case ({do_push, do_pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  ppbuf_ram #(
    .WIDTH(WIDTH),
    .DEPTH(DEPTH)
  ) u_ram (
    .clk   (clk),
    .we    (do_push),
    .waddr (wptr),
    .wdata (push_data),
    .re    (do_pop),
    .raddr (rptr),
    .rdata (pop_data)
  );
endmodule

// File: rtl/ppbuf_route.sv
module ppbuf_route (
  input  logic       bank_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] bank_empty,
  output logic [1:0] push_req,
  output logic [1:0] pop_req,
  output logic       rd_side_empty
);
  logic rd_bank;

  // write side is the bank named by the select, read side the other one
  assign rd_bank = ~bank_sel;

  always_comb begin
    push_req = 2'b00;
    pop_req  = 2'b00;
    push_req[bank_sel] = wr_en;
    pop_req[rd_bank]   = rd_en;
  end

  assign rd_side_empty = bank_empty[rd_bank];
endmodule

// File: rtl/pp_dual_fifo.sv
module pp_dual_fifo #(
  parameter int unsigned WIDTH = ppbuf_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH = ppbuf_pkg::DEF_DEPTH,
  localparam int unsigned CW = ppbuf_pkg::cnt_bits(DEPTH),
  localparam int unsigned NB = ppbuf_pkg::NUM_BANKS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bank_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);
  logic [NB-1:0]    push_req, pop_req, popped, b_empty, b_full;
  logic [WIDTH-1:0] b_data [NB];
  logic [CW-1:0]    b_level [NB];
  logic [CW-1:0]    level_a, level_b;
  logic             last_bank;

  ppbuf_route u_route (
    .bank_sel      (bank_sel),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .bank_empty    (b_empty),
    .push_req      (push_req),
    .pop_req       (pop_req),
    .rd_side_empty (empty)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    ppbuf_bank #(
      .WIDTH(WIDTH),
      .DEPTH(DEPTH)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .push_req  (push_req[g]),
      .push_data (wr_data),
      .pop_req   (pop_req[g]),
      .pop_data  (b_data[g]),
      .popped    (popped[g]),
      .is_empty  (b_empty[g]),
      .is_full   (b_full[g]),
      .level     (b_level[g])
    );
  end

  // remembers which bank's output register holds the latest popped word
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      last_bank <= ppbuf_pkg::BANK_A;
    end else if (popped[0]) begin
      last_bank <= ppbuf_pkg::BANK_A;
    end else if (popped[1]) begin
      last_bank <= ppbuf_pkg::BANK_B;
    end
  end

  assign rd_data = last_bank ? b_data[1] : b_data[0];
  assign level_a = b_level[0];
  assign level_b = b_level[1];

  logic unused_full;
  assign unused_full = ^b_full;
endmodule

// File: rtl/pp_dual_fifo_chk.sv
module pp_dual_fifo_chk #(
  parameter int unsigned WIDTH = 20,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = ppbuf_pkg::cnt_bits(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             bank_sel,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             empty,
  input logic [CW-1:0]    level_a,
  input logic [CW-1:0]    level_b
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  // R1: select 0 routes a write into bank A
  a_r1_write_to_a: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bank_sel && level_a < FULL_LVL) |=> level_a == $past(level_a) + 1'b1);

  // R1: select 1 routes a write into bank B
  a_r1_write_to_b: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank_sel && level_b < FULL_LVL) |=> level_b == $past(level_b) + 1'b1);

  // R7: a full bank never grows
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (level_a <= FULL_LVL) && (level_b <= FULL_LVL));

  // R8: reading an empty side keeps the output word
  a_r8_hold_on_empty: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> $stable(rd_data));

  // R10: concurrent read and write act on opposite banks
  a_r10_concurrent: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && !bank_sel && !empty && level_a < FULL_LVL)
      |=> (level_a == $past(level_a) + 1'b1) && (level_b == $past(level_b) - 1'b1));

  // R2: empty flag never hides a stored word on the read side
  a_r2_empty_read_side: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en && $stable(bank_sel) && !empty) |=> !empty);
endmodule

bind pp_dual_fifo pp_dual_fifo_chk #(
  .WIDTH(WIDTH),
  .DEPTH(DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bank_sel (bank_sel),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .empty    (empty),
  .level_a  (level_a),
  .level_b  (level_b)
);

// File: tb/pp_dual_fifo_tb.sv
`timescale 1ns/1ps
module pp_dual_fifo_tb;
  localparam int unsigned W = 20;
  localparam int unsigned D = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bank_sel = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [W-1:0] rd_data;
  logic         empty;

  int n_checks = 0;
  int n_errors = 0;

  logic [W-1:0] qa [$];
  logic [W-1:0] qb [$];
  logic [W-1:0] exp_rd = '0;
  bit           have_rd = 0;
  int           seed_n = 0;

  always #4 clk = ~clk;

  pp_dual_fifo u_dut (
    .clk      (clk),
    .rst      (rst),
    .bank_sel (bank_sel),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .empty    (empty)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int k);
    return W'((k * 40503 + 977) & ((1 << W) - 1));
  endfunction

  function automatic bit model_empty();
    return bank_sel ? (qa.size() == 0) : (qb.size() == 0);
  endfunction

  // one cycle: drive at the falling edge, model the rising edge, check at the next falling edge
  task automatic step(input string tag, input bit sel, input bit wr, input bit rd);
    logic [W-1:0] wd;
    wd = pattern(seed_n);
    seed_n++;
    bank_sel = sel;
    wr_en    = wr;
    rd_en    = rd;
    wr_data  = wd;
    @(posedge clk);
    if (rd) begin
      if (!sel && qb.size() > 0) begin exp_rd = qb.pop_front(); have_rd = 1; end
      if (sel && qa.size() > 0)  begin exp_rd = qa.pop_front(); have_rd = 1; end
    end
    if (wr) begin
      if (!sel && qa.size() < D) qa.push_back(wd);
      if (sel && qb.size() < D)  qb.push_back(wd);
    end
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    chk({tag, " empty"}, W'(empty), W'(model_empty()));
    if (have_rd) chk({tag, " rd_data"}, rd_data, exp_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset empty", W'(empty), W'(1));
    rst = 1'b0;
    @(negedge clk);

    // R4 / R2: fill A while B (read side) stays empty
    for (int i = 0; i < 3; i++) step("R2", 1'b0, 1'b1, 1'b0);
    chk("R2 still empty", W'(empty), W'(1));

    // R1: flip select, empty follows A now
    bank_sel = 1'b1;
    #1;
    chk("R1 swap empty", W'(empty), W'(0));

    // R5 / R10: drain A while writing B
    for (int i = 0; i < 3; i++) step("R10", 1'b1, 1'b1, 1'b1);

    // R8: read of empty A holds data
    for (int i = 0; i < 2; i++) step("R8", 1'b1, 1'b0, 1'b1);

    // R3 / R9: bursts into A with select flips in between
    for (int i = 0; i < 10; i++) step("R3", 1'b0, 1'b1, i % 3 == 0);
    for (int i = 0; i < 5; i++)  step("R9", 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step("R3", 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 25; i++) step("R3", 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 15; i++) step("R9", 1'b0, 1'b0, 1'b1);

    // R7: overfill A past DEPTH, then drain it completely
    for (int i = 0; i < D + 6; i++) step("R7", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < D + 2; i++) step("R7", 1'b1, 1'b0, 1'b1);
    chk("R7 drained", W'(empty), W'(1));

    // R1: mixed sweep of strobes and select
    for (int i = 0; i < 400; i++)
      step("R1", 1'(i / 37), 1'(i % 2 == 0 || i % 5 == 0), 1'(i % 3 != 0));

    // R6: asynchronous reset mid-cycle
    for (int i = 0; i < 4; i++) step("R6", 1'b1, 1'b1, 1'b0);
    bank_sel = 1'b0;
    #1;
    chk("R6 pre-reset", W'(empty), W'(0));
    rst = 1'b1;
    #1;
    chk("R6 async", W'(empty), W'(1));
    bank_sel = 1'b1;
    #1;
    chk("R6 other bank", W'(empty), W'(1));
    qa.delete();
    qb.delete();
    have_rd = 0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) step("R6", 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step("R4", 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 22; i++) step("R5", 1'b1, 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule